// File: doc/BRIEF.md
# Dual Complex-Weighted Beamformer with Power Integration

This block takes one complex baseband sample per channel per clock from a set of antenna channels and forms two beams from them at the same time. Every channel sample is multiplied by a programmable complex weight. Each beam has its own set of weights. For each beam the weighted samples are summed over all channels. The squared magnitude of the beam sum is then accumulated over a run-time number of samples. When an integration period closes, the two accumulated powers are rounded and presented together with a one-cycle strobe.

The weights live in a small register file that is written through an address/data/enable port. A write lands in a staging copy. The staging copy is transferred to the working copy only when the first sample of a period is accepted, so every period is computed with one consistent weight set. The block accepts a new sample on every clock with no stalls. Periods may follow one another with no idle cycle between them.

Top module: `bf_dual_beam`

## Requirements
- R1: After reset, `out_valid` is low, both power outputs are zero and every weight entry is zero, so a period streamed before any weight write yields zero power on both beams.
- R2: For each beam b, the power is the sum over the accepted samples of a period of re²+im² of the beam sum S_b = Σ_c g_b,c·x_c. Channel c's sample is the signed two's-complement field `[c*SW +: SW]` of `in_re`/`in_im`. Weights are signed 16-bit. The accumulation is exact for any length up to 65536.
- R3: A rising edge with `gw_en` high stores `gw_re`/`gw_im` into the entry selected by `gw_addr`. The top address bit selects the beam (0 or 1) and the lower bits select the channel. An address whose channel field is N_CH or more changes no entry.
- R4: `len_m1` is sampled with the first sample of each period, and the period length is `len_m1`+1. A value of 0 is taken as 1, which gives a range of 2 to 65536. Changing `len_m1` inside a period does not alter that period.
- R5: A cycle with `in_valid` low is neither counted nor accumulated.
- R6: A period uses the weights held in the register file at the cycle its first sample is accepted. A write made during a period first affects the following period.
- R7: `out_valid` is high for exactly one cycle, for both beams at once. It goes high after the fourth rising edge, counting the edge that accepts a period's last sample. Both accumulators restart from zero, so back-to-back periods lose no sample.
- R8: Each output equals floor((total + 2^(OUT_SHIFT-1)) / 2^OUT_SHIFT). Rounding is applied only here.
- R9: Between strobes the power outputs hold the value of the most recent strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | A sample is present on `in_re`/`in_im` this cycle |
| in_re | input | N_CH*SW | Real parts, channel c in bits [c*SW +: SW] |
| in_im | input | N_CH*SW | Imaginary parts, same packing |
| len_m1 | input | 16 | Integration length minus one, sampled at period start |
| gw_en | input | 1 | Weight write enable |
| gw_addr | input | clog2(N_CH)+1 | {beam, channel} of the weight entry |
| gw_re | input | 16 | Real part of the weight to write |
| gw_im | input | 16 | Imaginary part of the weight to write |
| out_valid | output | 1 | One-cycle strobe at the end of each period |
| out_pow0 | output | OUT_W | Rounded integrated power of beam 0 |
| out_pow1 | output | OUT_W | Rounded integrated power of beam 1 |

## Verification
A corrupted weight entry, a wrong product or a lost carry in the channel sum shows up as a mismatched power on the very next strobe. A bad period counter shows up as a strobe in the wrong cycle or a missing one. An accumulator that is not cleared, or that picks up an idle cycle, inflates every later period. A weight swapped at the wrong time spoils exactly one period: either the period with the mid-period write or the one after it. The bench predicts each strobe's cycle and both powers from its own model, so any of these faults is reported at the first period it touches.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int GAIN_W = 16;
  localparam int LEN_W  = 16;

  typedef struct packed {
    logic signed [GAIN_W-1:0] re;
    logic signed [GAIN_W-1:0] im;
  } gain_t;
endpackage

// File: rtl/bf_gain_bank.sv
module bf_gain_bank
  import bf_pkg::*;
#(
  parameter int N_CH = 12,
  parameter int CW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CW:0]             wr_addr,
  input  gain_t                   wr_val,
  input  logic                    at_start,
  input  logic                    take,
  output gain_t [1:0][N_CH-1:0]   gains
);
  logic          wr_beam;
  logic [CW-1:0] wr_ch;
  logic          in_range;
  gain_t [1:0][N_CH-1:0] shd_q, shd_d, act_q, act_d;

  assign wr_beam  = wr_addr[CW];
  assign wr_ch    = wr_addr[CW-1:0];
  assign in_range = ({1'b0, wr_ch} < (CW+1)'(N_CH));

  always_comb begin
    shd_d = shd_q;
    act_d = act_q;
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < N_CH; c++) begin
        if (wr_en && in_range && (wr_beam == 1'(b)) && (wr_ch == CW'(c)))
          shd_d[b][c] = wr_val;
        if (take)
          act_d[b][c] = shd_q[b][c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
    end
  end

  // the first sample of a period sees the staged set directly
  assign gains = at_start ? shd_q : act_q;

  p_oob_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> $stable(shd_q));

  p_gain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(act_q));
endmodule

// File: rtl/bf_beam_lane.sv
module bf_beam_lane
  import bf_pkg::*;
#(
  parameter int N_CH = 12,
  parameter int SW   = 12,
  parameter int MW   = 29,
  parameter int BW   = 33,
  parameter int PW   = 66
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_last,
  input  logic [N_CH*SW-1:0]   in_re,
  input  logic [N_CH*SW-1:0]   in_im,
  input  gain_t [N_CH-1:0]     gains,
  output logic                 pw_valid,
  output logic                 pw_last,
  output logic [PW-1:0]        pw
);
  // stage 1: per-channel complex products
  logic signed [MW-1:0] pr_q [N_CH];
  logic signed [MW-1:0] pi_q [N_CH];
  logic v1_q, l1_q, v2_q, l2_q, v3_q, l3_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic signed [MW-1:0] xr, xi, gr, gi, pr_d, pi_d;
    always_comb begin
      xr   = MW'($signed(in_re[c*SW +: SW]));
      xi   = MW'($signed(in_im[c*SW +: SW]));
      gr   = MW'(gains[c].re);
      gi   = MW'(gains[c].im);
      pr_d = xr * gr - xi * gi;
      pi_d = xr * gi + xi * gr;
    end
    always_ff @(posedge clk) begin
      if (in_valid) begin
        pr_q[c] <= pr_d;
        pi_q[c] <= pi_d;
      end
    end
  end

  // stage 2: channel sum
  logic signed [BW-1:0] sr_d, si_d, sr_q, si_q;
  always_comb begin
    sr_d = '0;
    si_d = '0;
    for (int c = 0; c < N_CH; c++) begin
      sr_d = sr_d + BW'(pr_q[c]);
      si_d = si_d + BW'(pi_q[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (v1_q) begin
      sr_q <= sr_d;
      si_q <= si_d;
    end
  end

  // stage 3: squared magnitude
  logic signed [PW-1:0] er, ei, sq;
  logic [PW-1:0]        pw_d, pw_q;
  always_comb begin
    er   = PW'(sr_q);
    ei   = PW'(si_q);
    sq   = er * er + ei * ei;
    pw_d = PW'(unsigned'(sq));
  end

  always_ff @(posedge clk) begin
    if (v2_q) pw_q <= pw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0; l1_q <= 1'b0;
      v2_q <= 1'b0; l2_q <= 1'b0;
      v3_q <= 1'b0; l3_q <= 1'b0;
    end else begin
      v1_q <= in_valid; l1_q <= in_valid && in_last;
      v2_q <= v1_q;     l2_q <= l1_q;
      v3_q <= v2_q;     l3_q <= l2_q;
    end
  end

  assign pw_valid = v3_q;
  assign pw_last  = l3_q;
  assign pw       = pw_q;

  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pw_last |-> pw_valid);
endmodule

// File: rtl/bf_integrator.sv
module bf_integrator #(
  parameter int PW        = 66,
  parameter int ACC_W     = 82,
  parameter int OUT_SHIFT = 8,
  parameter int OUT_W     = 74
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pw_valid,
  input  logic             pw_last,
  input  logic [PW-1:0]    pw,
  output logic             o_valid,
  output logic [OUT_W-1:0] o_pow
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (OUT_SHIFT - 1);

  logic [ACC_W-1:0] acc_q, acc_d, total, rnd;
  logic             ov_q, ov_d;
  logic [OUT_W-1:0] op_q, op_d;

  always_comb begin
    total = acc_q + ACC_W'(pw);
    rnd   = total + HALF;
    ov_d  = pw_valid && pw_last;
    op_d  = ov_d ? rnd[ACC_W-1:OUT_SHIFT] : op_q;
    acc_d = acc_q;
    if (pw_valid) acc_d = pw_last ? '0 : total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ov_q  <= 1'b0;
      op_q  <= '0;
    end else begin
      acc_q <= acc_d;
      ov_q  <= ov_d;
      op_q  <= op_d;
    end
  end

  assign o_valid = ov_q;
  assign o_pow   = op_q;

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid |-> (total >= acc_q));

  p_round_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_valid && pw_last) |-> (rnd >= total));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |=> !o_valid);

  p_acc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_valid && pw_last) |=> (acc_q == '0));
endmodule

// File: rtl/bf_dual_beam.sv
module bf_dual_beam
  import bf_pkg::*;
#(
  parameter int N_CH      = 12,
  parameter int SW        = 12,
  parameter int OUT_SHIFT = 8,
  localparam int CW       = $clog2(N_CH),
  localparam int AW       = CW + 1,
  localparam int MW       = SW + GAIN_W + 1,
  localparam int BW       = MW + $clog2(N_CH),
  localparam int PW       = 2 * BW,
  localparam int ACC_W    = PW + LEN_W,
  localparam int OUT_W    = ACC_W - OUT_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [N_CH*SW-1:0]   in_re,
  input  logic [N_CH*SW-1:0]   in_im,
  input  logic [LEN_W-1:0]     len_m1,
  input  logic                 gw_en,
  input  logic [AW-1:0]        gw_addr,
  input  logic [GAIN_W-1:0]    gw_re,
  input  logic [GAIN_W-1:0]    gw_im,
  output logic                 out_valid,
  output logic [OUT_W-1:0]     out_pow0,
  output logic [OUT_W-1:0]     out_pow1
);
  // reset: asserted asynchronously, released on the clock
  logic rs_meta_q, rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  // period counter
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d, len_req;
  logic             at_start, smp_last;

  always_comb begin
    len_req  = (len_m1 == '0) ? LEN_W'(1) : len_m1;
    at_start = (cnt_q == '0);
    smp_last = in_valid && !at_start && (cnt_q == len_q);
    cnt_d    = cnt_q;
    len_d    = len_q;
    if (in_valid) begin
      cnt_d = smp_last ? '0 : cnt_q + LEN_W'(1);
      if (at_start) len_d = len_req;
    end
  end

  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      cnt_q <= '0;
      len_q <= LEN_W'(1);
    end else begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  // weights
  gain_t                 wr_val;
  gain_t [1:0][N_CH-1:0] gains;
  assign wr_val = {gw_re, gw_im};

  bf_gain_bank #(.N_CH(N_CH), .CW(CW)) u_bank (
    .clk      (clk),
    .rst_n    (rs_q),
    .wr_en    (gw_en),
    .wr_addr  (gw_addr),
    .wr_val   (wr_val),
    .at_start (at_start),
    .take     (at_start && in_valid),
    .gains    (gains)
  );

  // two beams
  logic [1:0]       pv, pl, ov;
  logic [PW-1:0]    pw [2];
  logic [OUT_W-1:0] op [2];

  for (genvar b = 0; b < 2; b++) begin : g_beam
    bf_beam_lane #(.N_CH(N_CH), .SW(SW), .MW(MW), .BW(BW), .PW(PW)) u_lane (
      .clk      (clk),
      .rst_n    (rs_q),
      .in_valid (in_valid),
      .in_last  (smp_last),
      .in_re    (in_re),
      .in_im    (in_im),
      .gains    (gains[b]),
      .pw_valid (pv[b]),
      .pw_last  (pl[b]),
      .pw       (pw[b])
    );

    bf_integrator #(.PW(PW), .ACC_W(ACC_W), .OUT_SHIFT(OUT_SHIFT), .OUT_W(OUT_W)) u_int (
      .clk      (clk),
      .rst_n    (rs_q),
      .pw_valid (pv[b]),
      .pw_last  (pl[b]),
      .pw       (pw[b]),
      .o_valid  (ov[b]),
      .o_pow    (op[b])
    );
  end

  assign out_valid = ov[0];
  assign out_pow0  = op[0];
  assign out_pow1  = op[1];

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rs_q)
    (cnt_q != '0) |-> ((cnt_q <= len_q) && (len_q != '0)));

  p_beams_aligned_r7: assert property (@(posedge clk) disable iff (!rs_q)
    ov[0] == ov[1]);
endmodule

// File: tb/tb_bf_dual_beam.sv
module tb_bf_dual_beam;
  localparam int CLK_NS    = 10;
  localparam int N_CH      = 12;
  localparam int SW        = 12;
  localparam int OUT_SHIFT = 8;
  localparam int CW        = $clog2(N_CH);
  localparam int AW        = CW + 1;
  localparam int OUT_W     = 2 * (SW + 16 + 1 + $clog2(N_CH)) + 16 - OUT_SHIFT;

  logic                 clk;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [N_CH*SW-1:0]   in_re = '0;
  logic [N_CH*SW-1:0]   in_im = '0;
  logic [15:0]          len_m1 = '0;
  logic                 gw_en = 1'b0;
  logic [AW-1:0]        gw_addr = '0;
  logic [15:0]          gw_re = '0;
  logic [15:0]          gw_im = '0;
  logic                 out_valid;
  logic [OUT_W-1:0]     out_pow0, out_pow1;

  bf_dual_beam #(.N_CH(N_CH), .SW(SW), .OUT_SHIFT(OUT_SHIFT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .len_m1(len_m1), .gw_en(gw_en), .gw_addr(gw_addr), .gw_re(gw_re), .gw_im(gw_im),
    .out_valid(out_valid), .out_pow0(out_pow0), .out_pow1(out_pow1)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_NS/2) clk = ~clk;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [OUT_W-1:0] obs0[$], obs1[$], exp0[$], exp1[$];
  int obs_cyc[$], exp_cyc[$];

  always @(negedge clk) begin
    if (rst_n && out_valid === 1'b1) begin
      obs0.push_back(out_pow0);
      obs1.push_back(out_pow1);
      obs_cyc.push_back(cyc);
    end
  end

  int shd_re[2][N_CH], shd_im[2][N_CH], act_re[2][N_CH], act_im[2][N_CH];
  int fx_re[8][N_CH], fx_im[8][N_CH];
  logic [OUT_W-1:0] last0, last1;

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      gw_en    = 1'b0;
    end
  endtask

  task automatic write_gain(input int beam, input int ch, input int re, input int im);
    @(negedge clk);
    gw_en   = 1'b1;
    gw_addr = AW'({beam[0], ch[CW-1:0]});
    gw_re   = 16'(re);
    gw_im   = 16'(im);
    if (ch < N_CH) begin
      shd_re[beam][ch] = re;
      shd_im[beam][ch] = im;
    end
    @(negedge clk);
    gw_en = 1'b0;
  endtask

  // streams one period; mode 0 random samples, mode 1 fixed table
  task automatic stream(input int lm1, input int gap_pct, input int mode,
                        input bit mid_wr, input int mb, input int mc,
                        input int mre, input int mim);
    int len;
    logic [127:0] tot [2];
    len = (lm1 == 0) ? 2 : lm1 + 1;
    tot[0] = '0;
    tot[1] = '0;
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < N_CH; c++) begin
        act_re[b][c] = shd_re[b][c];
        act_im[b][c] = shd_im[b][c];
      end
    for (int i = 0; i < len; i++) begin
      while (gap_pct > 0 && $urandom_range(0, 99) < gap_pct) begin
        @(negedge clk);
        in_valid = 1'b0;
        gw_en    = 1'b0;
        in_re    = {N_CH{12'($urandom)}};
        len_m1   = 16'($urandom);
      end
      @(negedge clk);
      in_valid = 1'b1;
      gw_en    = 1'b0;
      len_m1   = (i == 0) ? 16'(lm1) : 16'($urandom);
      if (mid_wr && i == 1) begin
        gw_en   = 1'b1;
        gw_addr = AW'({mb[0], mc[CW-1:0]});
        gw_re   = 16'(mre);
        gw_im   = 16'(mim);
        shd_re[mb][mc] = mre;
        shd_im[mb][mc] = mim;
      end
      begin
        int xr[N_CH], xi[N_CH];
        for (int c = 0; c < N_CH; c++) begin
          if (mode == 0) begin
            xr[c] = int'($urandom_range(0, 4095)) - 2048;
            xi[c] = int'($urandom_range(0, 4095)) - 2048;
          end else begin
            xr[c] = fx_re[i % 8][c];
            xi[c] = fx_im[i % 8][c];
          end
          in_re[c*SW +: SW] = SW'(xr[c]);
          in_im[c*SW +: SW] = SW'(xi[c]);
        end
        for (int b = 0; b < 2; b++) begin
          longint sr, si;
          logic signed [127:0] a, q;
          sr = 0;
          si = 0;
          for (int c = 0; c < N_CH; c++) begin
            sr += longint'(act_re[b][c]) * xr[c] - longint'(act_im[b][c]) * xi[c];
            si += longint'(act_re[b][c]) * xi[c] + longint'(act_im[b][c]) * xr[c];
          end
          a = sr;
          q = si;
          tot[b] = tot[b] + unsigned'(a * a + q * q);
        end
      end
      if (i == len - 1) exp_cyc.push_back(cyc + 4);
    end
    for (int b = 0; b < 2; b++) begin
      logic [127:0] r;
      r = (tot[b] + (128'(1) << (OUT_SHIFT - 1))) >> OUT_SHIFT;
      if (b == 0) exp0.push_back(r[OUT_W-1:0]);
      else        exp1.push_back(r[OUT_W-1:0]);
    end
  endtask

  task automatic compare(input string tag);
    idle(8);
    check(obs0.size() == exp0.size(), {tag, " strobe count"}, obs0.size(), exp0.size());
    for (int k = 0; k < exp0.size() && k < obs0.size(); k++) begin
      check(obs0[k] == exp0[k], {tag, " beam0 power"}, obs0[k], exp0[k]);
      check(obs1[k] == exp1[k], {tag, " beam1 power"}, obs1[k], exp1[k]);
      check(obs_cyc[k] == exp_cyc[k], {tag, " R7 strobe cycle"}, obs_cyc[k], exp_cyc[k]);
    end
    if (exp0.size() > 0) begin
      last0 = exp0[exp0.size()-1];
      last1 = exp1[exp1.size()-1];
    end
    obs0.delete(); obs1.delete(); obs_cyc.delete();
    exp0.delete(); exp1.delete(); exp_cyc.delete();
  endtask

  task automatic load_random_gains();
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < N_CH; c++)
        write_gain(b, c, int'($urandom_range(0, 65535)) - 32768,
                         int'($urandom_range(0, 65535)) - 32768);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(out_pow0 == '0, "R1 out_pow0 after reset", out_pow0, 0);
    check(out_pow1 == '0, "R1 out_pow1 after reset", out_pow1, 0);
    stream(3, 0, 0, 1'b0, 0, 0, 0, 0);
    compare("R1 zero weights");
  endtask

  task automatic t_short();
    load_random_gains();
    stream(1, 0, 0, 1'b0, 0, 0, 0, 0);
    stream(0, 0, 0, 1'b0, 0, 0, 0, 0);
    compare("R2 R4 length two");
  endtask

  task automatic t_gaps();
    stream(36, 30, 0, 1'b0, 0, 0, 0, 0);
    stream(4, 50, 0, 1'b0, 0, 0, 0, 0);
    compare("R5 R2 gapped odd length");
  endtask

  task automatic t_back_to_back();
    stream(2, 0, 0, 1'b0, 0, 0, 0, 0);
    stream(4, 0, 0, 1'b0, 0, 0, 0, 0);
    stream(1, 0, 0, 1'b0, 0, 0, 0, 0);
    compare("R7 back to back");
    idle(5);
    check(out_pow0 == last0, "R9 beam0 hold", out_pow0, last0);
    check(out_pow1 == last1, "R9 beam1 hold", out_pow1, last1);
    check(out_valid == 1'b0, "R7 strobe low when idle", out_valid, 0);
  endtask

  task automatic t_gain_switch();
    stream(5, 0, 0, 1'b1, 1, 3, 12345, -23456);
    stream(5, 0, 0, 1'b1, 0, 7, -30000, 777);
    stream(5, 0, 0, 1'b0, 0, 0, 0, 0);
    compare("R6 mid-period write");
  endtask

  task automatic t_oob();
    write_gain(0, 13, 32767, 32767);
    write_gain(1, 15, -32768, 1000);
    write_gain(1, 12, 500, -500);
    stream(3, 0, 0, 1'b0, 0, 0, 0, 0);
    compare("R3 out-of-range address");
  endtask

  task automatic t_round();
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < N_CH; c++) write_gain(b, c, 0, 0);
    write_gain(0, 0, 1, 0);
    write_gain(1, 1, 1, 0);
    for (int i = 0; i < 8; i++)
      for (int c = 0; c < N_CH; c++) begin
        fx_re[i][c] = int'($urandom_range(0, 4095)) - 2048;
        fx_im[i][c] = int'($urandom_range(0, 4095)) - 2048;
      end
    // beam0 total 64+64=128 -> 1 ; beam1 total 98+29=127 -> 0
    fx_re[0][0] = 8; fx_im[0][0] = 0; fx_re[1][0] = 8; fx_im[1][0] = 0;
    fx_re[0][1] = 7; fx_im[0][1] = 7; fx_re[1][1] = 5; fx_im[1][1] = 2;
    stream(1, 0, 1, 1'b0, 0, 0, 0, 0);
    idle(8);
    check(obs0.size() == 1, "R8 strobe count", obs0.size(), 1);
    if (obs0.size() == 1) begin
      check(obs0[0] == OUT_W'(1), "R8 half rounds up", obs0[0], 1);
      check(obs1[0] == OUT_W'(0), "R8 below half rounds down", obs1[0], 0);
    end
    compare("R8 rounding model");
  endtask

  task automatic t_maxlen();
    for (int c = 0; c < N_CH; c++) begin
      write_gain(0, c, -32768, 0);
      write_gain(1, c, 32767, -32768);
    end
    for (int i = 0; i < 8; i++)
      for (int c = 0; c < N_CH; c++) begin
        fx_re[i][c] = -2048;
        fx_im[i][c] = -2048;
      end
    stream(65535, 0, 1, 1'b0, 0, 0, 0, 0);
    compare("R4 R2 longest period");
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < N_CH; c++) begin
        shd_re[b][c] = 0;
        shd_im[b][c] = 0;
      end
    t_reset();
    t_short();
    t_gaps();
    t_back_to_back();
    t_gain_switch();
    t_oob();
    t_round();
    t_maxlen();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule